// File: doc/BRIEF.md
# Vector Memory Element Sequencer

This block walks one vector memory instruction element by element. It turns a base address, an addressing mode and a run-time element count into a stream of element requests on a single memory port, one request per clock. For stores it reads each source element from a vector register and sends it with its address. For loads it writes the in-order read responses back into a destination vector register, one element per response.

Three addressing modes are served by the same sequencer. In contiguous mode, consecutive 64-bit elements are 8 bytes apart. In strided mode, consecutive elements are a programmable signed byte distance apart, which is how a matrix column is walked. In indexed mode, each address is the base plus a signed byte offset taken from the matching element of an index vector; this gives gather on loads and scatter on stores. The index element is read in the same cycle its address is formed. The vector registers sit outside the block, and the block reaches them through element read and write ports.

Top module: `vec_mem_seq`

## Requirements
- R1: While reset is held and after it is released, busy, done, req_valid and vd_we are low.
- R2: The number of element requests equals the requested length, limited to 64: a length of 100 issues exactly 64 requests.
- R3: A length of 0 issues no request, and done is high in the cycle that follows the accepted start.
- R4: With mode 0 (and also with mode 3), request i carries address base + 8*i.
- R5: With mode 1, request i carries address base + i*stride, where stride is a signed byte distance that may be negative.
- R6: With mode 2, during request i the index read port vi_ridx equals i, and the address is base + vi_rdata as a signed offset.
- R7: Requests are offered back to back; while req_valid is high and req_ready is low, the same element stays on offer until it is accepted.
- R8: For a store (is_store=1), req_we is 1 and req_wdata equals the source element read through vs_ridx = i; for a load, req_we is 0.
- R9: For a load, the k-th response (k counted from 0) raises vd_we with vd_widx = k and vd_wdata = rsp_data; a response that arrives while no load is running raises no vd_we.
- R10: done is a one-cycle pulse in the cycle after the last store request is accepted or after the last load element is written, and busy is low in that cycle.
- R11: A start that arrives while busy is high is ignored; the running instruction keeps its addresses and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| mode | input | 2 | 0 contiguous, 1 strided, 2 indexed, 3 as contiguous |
| is_store | input | 1 | 1 store/scatter, 0 load/gather |
| base | input | 64 | Base byte address |
| stride | input | 64 | Signed byte distance between elements in strided mode |
| vlen | input | 8 | Requested element count |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Element request on offer |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Element byte address |
| req_we | output | 1 | Request is a write |
| req_wdata | output | 64 | Store data |
| rsp_valid | input | 1 | In-order read data return |
| rsp_data | input | 64 | Read data |
| vd_we | output | 1 | Destination element write |
| vd_widx | output | 6 | Destination element position |
| vd_wdata | output | 64 | Destination element value |
| vs_ridx | output | 6 | Source element position for stores |
| vs_rdata | input | 64 | Source element value |
| vi_ridx | output | 6 | Index element position |
| vi_rdata | input | 64 | Index element value (signed byte offset) |

## Verification
The bench aims at the edges of the length register: 0, the full 64, and 100, which must clamp. A design that got these wrong would raise a request on an empty instruction, or run past the last element. Back-pressure is applied in an irregular pattern so that a design that advanced its address or index on offer rather than on acceptance would skip or repeat elements. Negative strides and negative index offsets catch address arithmetic that is not sign-correct. A start pushed in while the block is busy, and a stray read response outside a load, catch a sequencer that restarts mid-instruction or writes an element it does not own.

// File: rtl/vec_mem_pkg.sv
`timescale 1ns/1ps
// Shared types for the vector memory element sequencer.
package vec_mem_pkg;
    // Addressing mode carried on the mode input; the spare code behaves as contiguous.
    typedef enum logic [1:0] {
        AM_CONTIG = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2,
        AM_SPARE  = 2'd3
    } amode_e;
endpackage

// File: rtl/vec_mem_cnt.sv
`timescale 1ns/1ps
// Element position counter.
// Clears when an instruction is accepted and advances by one on each step.
// Assumes the owner never steps it past its width.
module vec_mem_cnt #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    // Hold, clear or advance the position.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/vec_mem_agen.sv
`timescale 1ns/1ps
// Element address generator.
// Latches base, stride and mode when an instruction is accepted. For the contiguous
// and strided modes it keeps a running address that moves on every accepted request,
// so no multiplier is needed. For the indexed mode it adds the current index element
// to the base in the same cycle. Assumes the index width equals the address width.
module vec_mem_agen
    import vec_mem_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int ELEM_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cfg,
    input  logic [1:0]        mode_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] stride_in,
    input  logic              step,
    input  logic [ADDR_W-1:0] idx_val,
    output logic [ADDR_W-1:0] addr
);
    amode_e            mode_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] stride_q;
    logic [ADDR_W-1:0] run_q;
    logic [ADDR_W-1:0] delta;

    // Distance between consecutive elements for the running address.
    always_comb begin
        delta = (mode_q == AM_STRIDE) ? stride_q : ADDR_W'(ELEM_BYTES);
    end

    // Capture the configuration and advance the running address on each acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= AM_CONTIG;
            base_q   <= '0;
            stride_q <= '0;
            run_q    <= '0;
        end else if (load_cfg) begin
            mode_q   <= amode_e'(mode_in);
            base_q   <= base_in;
            stride_q <= stride_in;
            run_q    <= base_in;
        end else if (step) begin
            run_q    <= run_q + delta;
        end
    end

    // Pick the indexed sum or the running address.
    always_comb begin
        addr = (mode_q == AM_INDEX) ? (base_q + idx_val) : run_q;
    end
endmodule

// File: rtl/vec_mem_seq.sv
`timescale 1ns/1ps
// Vector memory element sequencer (top).
// Accepts one instruction while idle. It then offers one element request per cycle
// on a valid/ready port and, for loads, writes in-order responses to consecutive
// destination elements. The vector registers are external and are read
// combinationally through the element read ports. Assumes VL_W covers NUM_ELEM.
module vec_mem_seq #(
    parameter int NUM_ELEM = 64,
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 64,
    parameter int VL_W     = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [1:0]                  mode,
    input  logic                        is_store,
    input  logic [ADDR_W-1:0]           base,
    input  logic [ADDR_W-1:0]           stride,
    input  logic [VL_W-1:0]             vlen,
    output logic                        busy,
    output logic                        done,
    output logic                        req_valid,
    input  logic                        req_ready,
    output logic [ADDR_W-1:0]           req_addr,
    output logic                        req_we,
    output logic [DATA_W-1:0]           req_wdata,
    input  logic                        rsp_valid,
    input  logic [DATA_W-1:0]           rsp_data,
    output logic                        vd_we,
    output logic [$clog2(NUM_ELEM)-1:0] vd_widx,
    output logic [DATA_W-1:0]           vd_wdata,
    output logic [$clog2(NUM_ELEM)-1:0] vs_ridx,
    input  logic [DATA_W-1:0]           vs_rdata,
    output logic [$clog2(NUM_ELEM)-1:0] vi_ridx,
    input  logic [DATA_W-1:0]           vi_rdata
);
    localparam int IDX_W      = $clog2(NUM_ELEM);
    localparam int CNT_W      = $clog2(NUM_ELEM + 1);
    localparam int ELEM_BYTES = DATA_W / 8;

    logic             active_q;
    logic             store_q;
    logic             done_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] len_eff;
    logic [CNT_W-1:0] iss_pos;
    logic [CNT_W-1:0] wr_pos;
    logic             accept;
    logic             fire;
    logic             last_iss;
    logic             last_wr;
    logic             finish;

    // Clamp the requested length to the register size.
    always_comb begin
        len_eff = (vlen > VL_W'(NUM_ELEM)) ? CNT_W'(NUM_ELEM) : CNT_W'(vlen);
    end

    // Handshake and completion terms.
    always_comb begin
        accept    = start && !active_q;
        req_valid = active_q && (iss_pos < count_q);
        fire      = req_valid && req_ready;
        vd_we     = active_q && !store_q && rsp_valid && (wr_pos < count_q);
        last_iss  = fire && (iss_pos == count_q - CNT_W'(1));
        last_wr   = vd_we && (wr_pos == count_q - CNT_W'(1));
        finish    = active_q && (store_q ? last_iss : last_wr);
    end

    // Instruction state: run flag, direction, element count and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            store_q  <= 1'b0;
            count_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (accept && (len_eff == '0)) || finish;
            if (accept) begin
                active_q <= (len_eff != '0);
                store_q  <= is_store;
                count_q  <= len_eff;
            end else if (finish) begin
                active_q <= 1'b0;
            end
        end
    end

    vec_mem_cnt #(.CNT_W(CNT_W)) u_iss_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (fire),
        .cnt   (iss_pos)
    );

    vec_mem_cnt #(.CNT_W(CNT_W)) u_wr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (vd_we),
        .cnt   (wr_pos)
    );

    vec_mem_agen #(.ADDR_W(ADDR_W), .ELEM_BYTES(ELEM_BYTES)) u_agen (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_cfg  (accept),
        .mode_in   (mode),
        .base_in   (base),
        .stride_in (stride),
        .step      (fire),
        .idx_val   (ADDR_W'(vi_rdata)),
        .addr      (req_addr)
    );

    // Drive the element ports from the current positions.
    always_comb begin
        vs_ridx   = iss_pos[IDX_W-1:0];
        vi_ridx   = iss_pos[IDX_W-1:0];
        vd_widx   = wr_pos[IDX_W-1:0];
        vd_wdata  = rsp_data;
        req_we    = store_q;
        req_wdata = vs_rdata;
        busy      = active_q;
        done      = done_q;
    end
endmodule

// File: rtl/vec_mem_seq_chk.sv
`timescale 1ns/1ps
// Property checker for the vector memory element sequencer, bound to the top.
// Watches only the top's ports, plus a local count of accepted requests.
module vec_mem_seq_chk #(
    parameter int NUM_ELEM = 64,
    parameter int VL_W     = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [VL_W-1:0] vlen,
    input logic            busy,
    input logic            done,
    input logic            req_valid,
    input logic            req_ready,
    input logic            vd_we
);
    logic [31:0] fire_cnt;

    // Count accepted requests since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                 fire_cnt <= '0;
        else if (start && !busy)    fire_cnt <= '0;
        else if (req_valid && req_ready) fire_cnt <= fire_cnt + 32'd1;
    end

    p_quiet_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !busy && !done && !req_valid && !vd_we);

    p_cap_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_cnt <= NUM_ELEM);

    p_empty_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (vlen == '0) |=> done && !req_valid);

    p_hold_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !req_valid);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && !(start && !busy) |=> !done);

    p_start_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && (vlen != '0) |=> busy);
endmodule

bind vec_mem_seq vec_mem_seq_chk #(.NUM_ELEM(NUM_ELEM), .VL_W(VL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vlen      (vlen),
    .busy      (busy),
    .done      (done),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .vd_we     (vd_we)
);

// File: tb/vec_mem_seq_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module vec_mem_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  mode;
    logic        is_store;
    logic [63:0] base;
    logic [63:0] stride;
    logic [7:0]  vlen;
    logic        busy;
    logic        done;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_addr;
    logic        req_we;
    logic [63:0] req_wdata;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        vd_we;
    logic [5:0]  vd_widx;
    logic [63:0] vd_wdata;
    logic [5:0]  vs_ridx;
    logic [63:0] vs_rdata;
    logic [5:0]  vi_ridx;
    logic [63:0] vi_rdata;

    logic [63:0] src_v [64];
    logic [63:0] idx_v [64];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign vs_rdata = src_v[vs_ridx];
    assign vi_rdata = idx_v[vi_ridx];

    vec_mem_seq u_vec_mem_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .is_store(is_store),
        .base(base), .stride(stride), .vlen(vlen), .busy(busy), .done(done),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .vd_we(vd_we), .vd_widx(vd_widx), .vd_wdata(vd_wdata),
        .vs_ridx(vs_ridx), .vs_rdata(vs_rdata), .vi_ridx(vi_ridx), .vi_rdata(vi_rdata)
    );

    function automatic logic [63:0] mem_word(input logic [63:0] a);
        return {a[31:0], ~a[63:32]} ^ 64'h5EED_0F0F_1234_A5A5;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Run one instruction and check every request, write and the completion pulse.
    task automatic run_op(input logic [1:0] md, input bit st, input logic [63:0] b,
                          input logic [63:0] s, input logic [7:0] vl,
                          input bit stall, input bit poke);
        int n = (vl > 8'd64) ? 64 : int'(vl);
        int ei = 0;
        int wr = 0;
        int dones = 0;
        bit exp_done;
        logic [63:0] exp_a;
        logic [63:0] pend_a[$];
        int pend_t[$];
        logic [63:0] cur_a;
        @(negedge clk);
        mode = md; is_store = st; base = b; stride = s; vlen = vl; start = 1'b1;
        exp_done = (n == 0);
        for (int cyc = 0; cyc < 600; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && cyc == 3) begin
                start = 1'b1; base = b ^ 64'hFFFF_0000; vlen = 8'd0; // R11 late start
            end
            rsp_valid = 1'b0;
            cur_a = '0;
            if (pend_t.size() > 0 && pend_t[0] <= cyc) begin
                cur_a = pend_a.pop_front();
                void'(pend_t.pop_front());
                rsp_valid = 1'b1;
                rsp_data = mem_word(cur_a);
            end
            req_ready = stall ? (cyc % 3 != 1) : 1'b1;
            #1;
            chk(done == exp_done, (n == 0) ? "R3" : "R10", "done timing", 64'(done), 64'(exp_done));
            if (done) begin
                dones++;
                chk(!busy, "R10", "busy with done", 64'(busy), 64'd0);
            end
            exp_done = 1'b0;
            if (req_valid) begin
                chk(ei < n, "R2", "request beyond length", 64'(ei), 64'(n));
                case (md)
                    2'd1:    exp_a = b + s * 64'(ei);
                    2'd2:    exp_a = b + idx_v[ei];
                    default: exp_a = b + 64'(8 * ei);
                endcase
                chk(req_addr == exp_a, (md == 2'd1) ? "R5" : (md == 2'd2) ? "R6" : "R4",
                    "element address", req_addr, exp_a);
                chk(req_we == st, "R8", "write enable", 64'(req_we), 64'(st));
                if (md == 2'd2) chk(vi_ridx == 6'(ei), "R6", "index read position", 64'(vi_ridx), 64'(ei));
                if (st) chk(req_wdata == src_v[ei], "R8", "store data", req_wdata, src_v[ei]);
                if (req_ready) begin
                    if (!st) begin pend_a.push_back(exp_a); pend_t.push_back(cyc + 2); end
                    ei++;
                    if (st && ei == n) exp_done = 1'b1;
                end
            end
            if (rsp_valid && !st) begin
                chk(vd_we, "R9", "response write enable", 64'(vd_we), 64'd1);
                chk(vd_widx == 6'(wr), "R9", "response position", 64'(vd_widx), 64'(wr));
                chk(vd_wdata == mem_word(cur_a), "R9", "response data", vd_wdata, mem_word(cur_a));
                wr++;
                if (wr == n) exp_done = 1'b1;
            end else begin
                chk(!vd_we, "R9", "spurious write", 64'(vd_we), 64'd0);
            end
            if (done) break;
        end
        chk(ei == n, "R2", "requests issued", 64'(ei), 64'(n));
        chk(dones == 1, "R10", "done pulses", 64'(dones), 64'd1);
        @(negedge clk);
        rsp_valid = 1'b0; req_ready = 1'b0; start = 1'b0;
        #1;
        chk(!done && !busy, "R10", "idle after done", 64'({done, busy}), 64'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; start = 1'b0; mode = 2'd0; is_store = 1'b0; base = '0;
        stride = '0; vlen = '0; req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
        repeat (3) @(negedge clk);
        chk({busy, done, req_valid, vd_we} == 4'b0, "R1", "outputs in reset", 64'({busy, done, req_valid, vd_we}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, req_valid, vd_we} == 4'b0, "R1", "outputs after reset", 64'({busy, done, req_valid, vd_we}), 64'd0);
    endtask

    // R9: a response with no load running must not write.
    task automatic t_stray_rsp;
        @(negedge clk);
        rsp_valid = 1'b1; rsp_data = 64'hDEAD;
        #1;
        chk(!vd_we, "R9", "stray response", 64'(vd_we), 64'd0);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            src_v[i] = 64'hC0DE_0000_0000_0000 + 64'(i * 97);
            idx_v[i] = (i % 2 == 0) ? 64'(i * 40) : -64'(i * 24);
        end
        t_reset();
        run_op(2'd0, 1'b0, 64'h1000, 64'd0, 8'd10, 1'b0, 1'b0);           // R4 R9 contiguous load
        run_op(2'd1, 1'b1, 64'h8000, -64'd72, 8'd12, 1'b1, 1'b0);         // R5 R7 R8 negative stride store
        run_op(2'd2, 1'b0, 64'h4_0000, 64'd0, 8'd16, 1'b1, 1'b0);         // R6 gather
        run_op(2'd2, 1'b1, 64'h5_0000, 64'd0, 8'd7, 1'b0, 1'b0);          // R6 R8 scatter
        run_op(2'd0, 1'b1, 64'h20_0000, 64'd0, 8'd100, 1'b0, 1'b1);       // R2 clamp, R11 late start
        run_op(2'd1, 1'b0, 64'h30_0000, 64'd800, 8'd0, 1'b0, 1'b0);       // R3 empty
        run_op(2'd3, 1'b0, 64'h40_0000, 64'd64, 8'd5, 1'b1, 1'b0);        // R4 spare mode
        t_stray_rsp();                                                    // R9
        run_op(2'd1, 1'b0, 64'h50_0000, 64'd800, 8'd64, 1'b1, 1'b0);      // R2 R7 full length
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule